// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write bus and the program/erase engine of a parallel flash array. It watches every write cycle (address plus data) and recognises the multi-cycle command sequences a host uses to drive the flash. Every sequence opens with a fixed pair of unlock writes. The third write picks the command. Some commands finish there. Byte program takes one more write carrying the target. The erase and lock commands go through a shared prefix code, a second unlock pair and a final selecting write.

When a sequence completes, the block raises exactly one single-cycle command pulse and holds the target address and data for the engine. It also keeps an identification mode flag. While the flag is set, reads at a few fixed locations return the manufacturer code, the device code and the boot-lock status in place of array data. The host read mux uses `id_mode` to pick `id_rdata` over the array.

Top module: `cmdseq_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, all four command pulses are low, `id_mode` is low and `id_rdata` is zero; a lone write with no unlock prefix does nothing.
- R2: A command is accepted only after 0xAA written at unlock address 0x5555 and then 0x55 at 0x2AAA; only address bits 14:0 are compared for these and for every other 0x5555 step, so 0x15555 and 0x3AAAA also qualify.
- R3: Unlock, then 0xA0 at 0x5555, then any write: `pgm_pulse` goes high in the cycle after that fourth write, and `tgt_addr`/`tgt_data` hold its address and data; a data value of 0xF0 here is program data and leaves `id_mode` alone.
- R4: Unlock, 0x80 at 0x5555, unlock again, then 0x10 at 0x5555 gives `chip_erase_pulse`.
- R5: The same prefix followed by 0x30 at any address gives `sec_erase_pulse`, with `tgt_addr` holding that address.
- R6: The same prefix followed by 0x40 at 0x5555 gives `lock_pulse`.
- R7: Unlock, then 0x90 at 0x5555, sets `id_mode`; in that mode `id_rdata` is 0x1F at read address 0, 0x07 at address 1, and zero at other addresses except the lock location.
- R8: In identification mode, read address 2 returns `lock_status` on bit 0 with all other bits zero.
- R9: `id_mode` is cleared by unlock followed by 0xF0 at 0x5555, or by a single 0xF0 written to any address at any step except the program data step.
- R10: A write whose address or data does not fit the current step sends the decoder back to idle, so later writes completing the pattern fire nothing.
- R11: Driving `rst_n` low part-way through a sequence aborts it and clears `id_mode`.
- R12: Each command pulse lasts exactly one cycle and at most one command pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe marking a host write |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 18 | Read address for identification lookup |
| lock_status | input | 1 | Boot-lock active flag from the array |
| pgm_pulse | output | 1 | Byte program request |
| sec_erase_pulse | output | 1 | Sector erase request |
| chip_erase_pulse | output | 1 | Chip erase request |
| lock_pulse | output | 1 | Boot-lock enable request |
| tgt_addr | output | 18 | Address of the last program or sector erase |
| tgt_data | output | 8 | Data of the last program |
| id_mode | output | 1 | Identification mode active |
| id_rdata | output | 8 | Identification read data, zero outside the mode |

## Verification
Complete sequences for each of the four commands show that the final selecting write alone decides which pulse fires. Broken sequences, with a wrong code or a wrong address at the second and fifth steps, show that a mismatch resets progress and does not just skip a step. Unlock addresses carrying set upper bits check that only the low fifteen bits are compared. An 0xF0 sent as program data, set against 0xF0 sent as a stray write, shows that mode exit depends on the sequence step.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

   // sequence steps
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_PGM,
      ST_PRE,
      ST_UNL3,
      ST_UNL4
   } seq_t;

   localparam logic [14:0] ADDR_FIRST  = 15'h5555;
   localparam logic [14:0] ADDR_SECOND = 15'h2AAA;

   // data code indices
   localparam int IX_AA    = 0;
   localparam int IX_55    = 1;
   localparam int IX_PGM   = 2;
   localparam int IX_IDIN  = 3;
   localparam int IX_EXIT  = 4;
   localparam int IX_PRE   = 5;
   localparam int IX_CHIP  = 6;
   localparam int IX_SECT  = 7;
   localparam int IX_LOCK  = 8;
   localparam int NUM_CODES = 9;

   localparam logic [7:0] CODE_LIST [NUM_CODES] = '{
      8'hAA, 8'h55, 8'hA0, 8'h90, 8'hF0, 8'h80, 8'h10, 8'h30, 8'h40
   };

   // command pulse bit positions
   localparam int CMD_LOCK = 0;
   localparam int CMD_CHIP = 1;
   localparam int CMD_SEC  = 2;
   localparam int CMD_PGM  = 3;
   localparam int NUM_CMDS = 4;

endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match
   import cmdseq_pkg::*;
#(
   parameter int CMP_W  = 15,
   parameter int DATA_W = 8
) (
   input  logic [CMP_W-1:0]     cmp_addr,
   input  logic [DATA_W-1:0]    wr_data,
   output logic                 at_first,
   output logic                 at_second,
   output logic [NUM_CODES-1:0] dhit
);

   if (CMP_W < 15) begin : g_bad_cmp
      $error("cmdseq_match: CMP_W must be at least 15");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("cmdseq_match: DATA_W must be at least 8");
   end

   assign at_first  = (cmp_addr == CMP_W'(ADDR_FIRST));
   assign at_second = (cmp_addr == CMP_W'(ADDR_SECOND));

   for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
      if (DATA_W == 8) begin : g_exact
         assign dhit[i] = (wr_data == CODE_LIST[i]);
      end else begin : g_wide
         assign dhit[i] = (wr_data[7:0] == CODE_LIST[i]) &&
                          (wr_data[DATA_W-1:8] == '0);
      end
   end

endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
   import cmdseq_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 at_first,
   input  logic                 at_second,
   input  logic [NUM_CODES-1:0] dhit,
   output logic [NUM_CMDS-1:0]  cmd_pulse,
   output logic [ADDR_W-1:0]    tgt_addr,
   output logic [DATA_W-1:0]    tgt_data,
   output logic                 id_mode
);

   seq_t                state, state_nxt;
   logic [NUM_CMDS-1:0] fire;
   logic                id_set, id_clr;

   always_comb begin
      state_nxt = state;
      fire      = '0;
      id_set    = 1'b0;
      id_clr    = 1'b0;
      if (wr_en) begin
         state_nxt = ST_IDLE;
         if (dhit[IX_EXIT] && state != ST_PGM) begin
            id_clr = 1'b1;
         end else begin
            unique case (state)
               ST_IDLE: if (at_first && dhit[IX_AA])   state_nxt = ST_UNL1;
               ST_UNL1: if (at_second && dhit[IX_55])  state_nxt = ST_UNL2;
               ST_UNL2: if (at_first) begin
                  if (dhit[IX_PGM])       state_nxt = ST_PGM;
                  else if (dhit[IX_PRE])  state_nxt = ST_PRE;
                  else if (dhit[IX_IDIN]) id_set    = 1'b1;
               end
               ST_PGM:  fire[CMD_PGM] = 1'b1;
               ST_PRE:  if (at_first && dhit[IX_AA])   state_nxt = ST_UNL3;
               ST_UNL3: if (at_second && dhit[IX_55])  state_nxt = ST_UNL4;
               ST_UNL4: begin
                  if (at_first && dhit[IX_CHIP])      fire[CMD_CHIP] = 1'b1;
                  else if (dhit[IX_SECT])             fire[CMD_SEC]  = 1'b1;
                  else if (at_first && dhit[IX_LOCK]) fire[CMD_LOCK] = 1'b1;
               end
               default: state_nxt = ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cmd_pulse <= '0;
         tgt_addr  <= '0;
         tgt_data  <= '0;
         id_mode   <= 1'b0;
      end else begin
         state     <= state_nxt;
         cmd_pulse <= fire;
         if (fire[CMD_PGM] || fire[CMD_SEC]) begin
            tgt_addr <= wr_addr;
            tgt_data <= wr_data;
         end
         if (id_set)      id_mode <= 1'b1;
         else if (id_clr) id_mode <= 1'b0;
      end
   end

   // R12: never two commands at once
   assert_pulse_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_pulse));

   // R12: a pulse never stretches
   assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmd_pulse) |=> !(|cmd_pulse));

   // R3: every command stems from a write in the cycle before
   assert_pulse_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmd_pulse) |-> $past(wr_en));

   // R4: chip erase only follows its selecting code
   assert_chip_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pulse[CMD_CHIP] |-> ($past(wr_data) == DATA_W'(CODE_LIST[IX_CHIP])));

   // R7: the mode is entered only by its code
   assert_id_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> ($past(wr_en) && $past(wr_data) == DATA_W'(CODE_LIST[IX_IDIN])));

   // R9: the mode is left only through the exit code
   assert_id_leave_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(id_mode) |-> ($past(wr_en) && $past(wr_data) == DATA_W'(CODE_LIST[IX_EXIT])));

endmodule

// File: rtl/cmdseq_idread.sv
module cmdseq_idread #(
   parameter int         ADDR_W   = 18,
   parameter int         DATA_W   = 8,
   parameter logic [7:0] MFR_CODE = 8'h1F,
   parameter logic [7:0] DEV_CODE = 8'h07,
   parameter int         LOCK_LOC = 2
) (
   input  logic              id_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              lock_status,
   output logic [DATA_W-1:0] id_rdata
);

   if (LOCK_LOC < 2) begin : g_bad_loc
      $error("cmdseq_idread: LOCK_LOC collides with the code locations");
   end

   always_comb begin
      id_rdata = '0;
      if (id_mode) begin
         if (rd_addr == ADDR_W'(0))             id_rdata = DATA_W'(MFR_CODE);
         else if (rd_addr == ADDR_W'(1))        id_rdata = DATA_W'(DEV_CODE);
         else if (rd_addr == ADDR_W'(LOCK_LOC)) id_rdata = DATA_W'(lock_status);
      end
   end

endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder
   import cmdseq_pkg::*;
#(
   parameter int         ADDR_W   = 18,
   parameter int         DATA_W   = 8,
   parameter int         CMP_W    = 15,
   parameter logic [7:0] MFR_CODE = 8'h1F,
   parameter logic [7:0] DEV_CODE = 8'h07,
   parameter int         LOCK_LOC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              lock_status,
   output logic              pgm_pulse,
   output logic              sec_erase_pulse,
   output logic              chip_erase_pulse,
   output logic              lock_pulse,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [DATA_W-1:0] tgt_data,
   output logic              id_mode,
   output logic [DATA_W-1:0] id_rdata
);

   if (CMP_W > ADDR_W) begin : g_bad_width
      $error("cmdseq_decoder: CMP_W exceeds ADDR_W");
   end

   logic                 at_first, at_second;
   logic [NUM_CODES-1:0] dhit;
   logic [NUM_CMDS-1:0]  cmd_pulse;

   cmdseq_match #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_match (
      .cmp_addr  (wr_addr[CMP_W-1:0]),
      .wr_data   (wr_data),
      .at_first  (at_first),
      .at_second (at_second),
      .dhit      (dhit)
   );

   cmdseq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .at_first  (at_first),
      .at_second (at_second),
      .dhit      (dhit),
      .cmd_pulse (cmd_pulse),
      .tgt_addr  (tgt_addr),
      .tgt_data  (tgt_data),
      .id_mode   (id_mode)
   );

   cmdseq_idread #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE),
      .LOCK_LOC (LOCK_LOC)
   ) u_idread (
      .id_mode     (id_mode),
      .rd_addr     (rd_addr),
      .lock_status (lock_status),
      .id_rdata    (id_rdata)
   );

   assign pgm_pulse        = cmd_pulse[CMD_PGM];
   assign sec_erase_pulse  = cmd_pulse[CMD_SEC];
   assign chip_erase_pulse = cmd_pulse[CMD_CHIP];
   assign lock_pulse       = cmd_pulse[CMD_LOCK];

endmodule

// File: tb/tb_cmdseq_decoder.sv
module tb_cmdseq_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [17:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [17:0] rd_addr = '0;
   logic        lock_status = 1'b0;
   logic        pgm_pulse, sec_erase_pulse, chip_erase_pulse, lock_pulse;
   logic [17:0] tgt_addr;
   logic [7:0]  tgt_data;
   logic        id_mode;
   logic [7:0]  id_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   cmdseq_decoder dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .lock_status (lock_status),
      .pgm_pulse (pgm_pulse), .sec_erase_pulse (sec_erase_pulse),
      .chip_erase_pulse (chip_erase_pulse), .lock_pulse (lock_pulse),
      .tgt_addr (tgt_addr), .tgt_data (tgt_data), .id_mode (id_mode),
      .id_rdata (id_rdata)
   );

   always #10 clk = ~clk;

   // {req, addr, data, pulses {pgm,sec,chip,lock}, id_mode}
   localparam int NV = 40;
   localparam logic [34:0] VEC [NV] = '{
      {4'd1, 18'h00000, 8'hA0, 4'b0000, 1'b0}, // R1 no prefix
      {4'd3, 18'h05555, 8'hAA, 4'b0000, 1'b0}, // R3 program
      {4'd3, 18'h02AAA, 8'h55, 4'b0000, 1'b0},
      {4'd3, 18'h05555, 8'hA0, 4'b0000, 1'b0},
      {4'd3, 18'h12345, 8'h3C, 4'b1000, 1'b0},
      {4'd4, 18'h05555, 8'hAA, 4'b0000, 1'b0}, // R4 chip erase
      {4'd4, 18'h02AAA, 8'h55, 4'b0000, 1'b0},
      {4'd4, 18'h05555, 8'h80, 4'b0000, 1'b0},
      {4'd4, 18'h05555, 8'hAA, 4'b0000, 1'b0},
      {4'd4, 18'h02AAA, 8'h55, 4'b0000, 1'b0},
      {4'd4, 18'h05555, 8'h10, 4'b0010, 1'b0},
      {4'd5, 18'h05555, 8'hAA, 4'b0000, 1'b0}, // R5 sector erase
      {4'd5, 18'h02AAA, 8'h55, 4'b0000, 1'b0},
      {4'd5, 18'h05555, 8'h80, 4'b0000, 1'b0},
      {4'd5, 18'h05555, 8'hAA, 4'b0000, 1'b0},
      {4'd5, 18'h02AAA, 8'h55, 4'b0000, 1'b0},
      {4'd5, 18'h21000, 8'h30, 4'b0100, 1'b0},
      {4'd6, 18'h05555, 8'hAA, 4'b0000, 1'b0}, // R6 boot lock
      {4'd6, 18'h02AAA, 8'h55, 4'b0000, 1'b0},
      {4'd6, 18'h05555, 8'h80, 4'b0000, 1'b0},
      {4'd6, 18'h05555, 8'hAA, 4'b0000, 1'b0},
      {4'd6, 18'h02AAA, 8'h55, 4'b0000, 1'b0},
      {4'd6, 18'h05555, 8'h40, 4'b0001, 1'b0},
      {4'd10, 18'h05555, 8'hAA, 4'b0000, 1'b0}, // R10 wrong second data
      {4'd10, 18'h02AAA, 8'h54, 4'b0000, 1'b0},
      {4'd10, 18'h05555, 8'hA0, 4'b0000, 1'b0},
      {4'd10, 18'h00100, 8'h77, 4'b0000, 1'b0},
      {4'd10, 18'h05555, 8'hAA, 4'b0000, 1'b0}, // R10 wrong fifth address
      {4'd10, 18'h02AAA, 8'h55, 4'b0000, 1'b0},
      {4'd10, 18'h05555, 8'h80, 4'b0000, 1'b0},
      {4'd10, 18'h05555, 8'hAA, 4'b0000, 1'b0},
      {4'd10, 18'h01555, 8'h55, 4'b0000, 1'b0},
      {4'd10, 18'h05555, 8'h10, 4'b0000, 1'b0},
      {4'd7, 18'h05555, 8'hAA, 4'b0000, 1'b0}, // R7 id entry
      {4'd7, 18'h02AAA, 8'h55, 4'b0000, 1'b0},
      {4'd7, 18'h05555, 8'h90, 4'b0000, 1'b1},
      {4'd2, 18'h15555, 8'hAA, 4'b0000, 1'b1}, // R2 upper bits ignored
      {4'd2, 18'h3AAAA, 8'h55, 4'b0000, 1'b1},
      {4'd2, 18'h25555, 8'hA0, 4'b0000, 1'b1},
      {4'd2, 18'h00400, 8'h5A, 4'b1000, 1'b1}
   };

   function automatic logic [3:0] pulses();
      return {pgm_pulse, sec_erase_pulse, chip_erase_pulse, lock_pulse};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [17:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      checks++; errors++;
      $display("FAIL R1 watchdog expired actual=%h expected=%h", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(pulses() == 4'b0 && !id_mode, "R1", "state in reset", {27'd0, pulses(), id_mode}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pulses() == 4'b0 && !id_mode && id_rdata == 8'h00, "R1", "state after reset",
          {19'd0, pulses(), id_mode, id_rdata}, 0);

      for (int i = 0; i < NV; i++) begin
         automatic logic [3:0]  rq = VEC[i][34:31];
         automatic logic [17:0] va = VEC[i][30:13];
         automatic logic [7:0]  vd = VEC[i][12:5];
         automatic logic [3:0]  ep = VEC[i][4:1];
         automatic logic        ei = VEC[i][0];
         automatic string       rs = $sformatf("R%0d", rq);
         wr(va, vd);
         chk(pulses() == ep, rs, $sformatf("pulses vec %0d", i), pulses(), ep);
         chk(id_mode == ei, rs, $sformatf("id_mode vec %0d", i), id_mode, ei);
         if (ep[3] || ep[2]) begin
            chk(tgt_addr == va, rs, "target address", tgt_addr, va);
            if (ep[3]) chk(tgt_data == vd, rs, "target data", tgt_data, vd);
         end
         if (ep != 4'b0) begin
            @(negedge clk);
            chk(pulses() == 4'b0, "R12", "pulse one cycle", pulses(), 0);
         end
      end

      // R7 / R8 identification reads
      rd_addr = 18'h0; @(negedge clk);
      chk(id_rdata == 8'h1F, "R7", "manufacturer code", id_rdata, 8'h1F);
      rd_addr = 18'h1; @(negedge clk);
      chk(id_rdata == 8'h07, "R7", "device code", id_rdata, 8'h07);
      rd_addr = 18'h3; @(negedge clk);
      chk(id_rdata == 8'h00, "R7", "other address", id_rdata, 8'h00);
      rd_addr = 18'h2; lock_status = 1'b0; @(negedge clk);
      chk(id_rdata == 8'h00, "R8", "lock clear", id_rdata, 8'h00);
      lock_status = 1'b1; @(negedge clk);
      chk(id_rdata == 8'h01, "R8", "lock set", id_rdata, 8'h01);

      // R3 corner: 0xF0 as program data keeps the mode
      wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0);
      wr(18'h00200, 8'hF0);
      chk(pgm_pulse && tgt_data == 8'hF0, "R3", "F0 programmed", {23'd0, pgm_pulse, tgt_data}, 32'h1F0);
      chk(id_mode, "R3", "mode kept", id_mode, 1);

      // R9 single-write exit
      rd_addr = 18'h0;
      wr(18'h12345, 8'hF0);
      chk(!id_mode, "R9", "single exit", id_mode, 0);
      chk(id_rdata == 8'h00, "R9", "reads off after exit", id_rdata, 0);

      // R9 three-write exit
      wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
      chk(id_mode, "R7", "re-entry", id_mode, 1);
      wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hF0);
      chk(!id_mode, "R9", "three-write exit", id_mode, 0);

      // R11 reset mid-sequence
      wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
      wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk(!id_mode, "R11", "reset clears mode", id_mode, 0);
      wr(18'h00100, 8'h11);
      chk(pulses() == 4'b0, "R11", "sequence aborted", pulses(), 0);

      finish_run();
   end

endmodule